// File: doc/BRIEF.md
# Overlapping 1101 Pattern Detector

This block watches a one-bit serial stream and reports every occurrence of the bit pattern 1, 1, 0, 1 (in arrival order). One input bit is taken on each rising clock edge. The detector is a Moore machine with five states. Each state records how much of the pattern the recent bits already match. One of the five states is a dedicated accept state, and the detect output is decoded from that state alone.

Matches may overlap. The last 1 of one match can serve as the first 1 of the next, so the stream 1101101 reports two hits. A high clear input returns the machine to its idle state at once, without waiting for a clock edge, and drops any partial match.

Top module: `pat1101_moore`

## Requirements
- R1: While `clr` is high the machine is idle and `hit` is 0. After `clr` falls, `hit` stays 0 until four bits have been sampled.
- R2: `hit` is 0 in every cycle in which the four bits most recently sampled since the last clear are not 1,1,0,1 (oldest first).
- R3: `hit` is 1 during the clock cycle that follows the rising edge at which the final 1 of a 1,1,0,1 run was sampled. The output lags that bit by exactly one clock.
- R4: `clr` acts asynchronously. Raising it between clock edges forces `hit` to 0 before the next edge. Bits sampled before the clear never count toward a later match.
- R5: Overlapping matches are reported. The stream 1,1,0,1,1,0,1 raises `hit` twice, three cycles apart.
- R6: `hit` is a single-cycle pulse and is never 1 in two consecutive cycles.
- R7: A run of extra 1s before the 0 does not lose the match. For example, 1,1,1,1,0,1 raises `hit` once, after the last bit.
- R8: The state register holds only the five legal state codes, which are 0 to 4 (idle, "1", "11", "110", "1101"). Any other code goes to idle at the next edge.
- R9: A 0 after the "110" prefix returns the machine to idle. In 1,1,0,0,1,1,0,1 only the final bit produces a hit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| clr | input | 1 | Asynchronous clear to idle, active high |
| din | input | 1 | Serial data bit |
| hit | output | 1 | High while the machine is in the accept state |

## Verification
A bit presented to `din` is sampled at the next rising edge. Any hit it completes is visible on `hit` right after that same edge, so every result is due one edge after its stimulus. The driver applies each bit on the falling edge and queues the expected `hit` value, which comes from a four-bit history model. The monitor pops and compares that value 1 ns after the following rising edge. Clear is the only result that does not wait for a clock: its effect is checked 1 ns after `clr` rises, in the middle of the cycle.

// File: rtl/pat1101_pkg.sv
`timescale 1ns/1ps
package pat1101_pkg;
  localparam int ST_W = 3;
  localparam int N_LEGAL = 5;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_P1   = 3'd1,
    ST_P11  = 3'd2,
    ST_P110 = 3'd3,
    ST_HIT  = 3'd4
  } pat_st_e;
endpackage

// File: rtl/pat_next_state.sv
`timescale 1ns/1ps
module pat_next_state
  import pat1101_pkg::*;
(
  input  pat_st_e cur,
  input  logic    bit_in,
  output pat_st_e nxt
);
  always_comb begin
    nxt = ST_IDLE;
    unique case (cur)
      ST_IDLE: nxt = bit_in ? ST_P1   : ST_IDLE;
      ST_P1:   nxt = bit_in ? ST_P11  : ST_IDLE;
      ST_P11:  nxt = bit_in ? ST_P11  : ST_P110;
      ST_P110: nxt = bit_in ? ST_HIT  : ST_IDLE;
      ST_HIT:  nxt = bit_in ? ST_P11  : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pat_state_reg.sv
`timescale 1ns/1ps
module pat_state_reg
  import pat1101_pkg::*;
(
  input  logic    clk,
  input  logic    clr,
  input  pat_st_e d,
  output pat_st_e q
);
  always_ff @(posedge clk or posedge clr) begin
    if (clr) q <= ST_IDLE;
    else     q <= d;
  end
endmodule

// File: rtl/pat_hit_decode.sv
`timescale 1ns/1ps
module pat_hit_decode
  import pat1101_pkg::*;
(
  input  pat_st_e st,
  output logic    hit
);
  assign hit = (st == ST_HIT);
endmodule

// File: rtl/pat1101_moore.sv
`timescale 1ns/1ps
module pat1101_moore
  import pat1101_pkg::*;
(
  input  logic clk,
  input  logic clr,
  input  logic din,
  output logic hit
);
  pat_st_e st_q;
  pat_st_e st_d;

  pat_next_state u_next (
    .cur    (st_q),
    .bit_in (din),
    .nxt    (st_d)
  );

  pat_state_reg u_reg (
    .clk (clk),
    .clr (clr),
    .d   (st_d),
    .q   (st_q)
  );

  pat_hit_decode u_dec (
    .st  (st_q),
    .hit (hit)
  );
endmodule

// File: rtl/pat1101_chk.sv
`timescale 1ns/1ps
module pat1101_chk
  import pat1101_pkg::*;
(
  input logic            clk,
  input logic            clr,
  input logic            din,
  input logic            hit,
  input logic [ST_W-1:0] st_q
);
  logic [3:0] hist;
  logic [2:0] seen;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      hist <= '0;
      seen <= '0;
    end else begin
      hist <= {hist[2:0], din};
      if (seen != 3'd4) seen <= seen + 3'd1;
    end
  end

  // R2 R3: output equals "last four sampled bits were 1101"
  p_match_window_r3: assert property (@(posedge clk) disable iff (clr)
    hit == ((seen == 3'd4) && (hist == 4'b1101)));

  // R1 R4: clear holds the output low
  p_clear_low_r4: assert property (@(posedge clk) clr |-> !hit);

  // R6: single-cycle pulse
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (clr)
    hit |=> !hit);

  // R3: a hit follows a sampled 1
  p_hit_after_one_r3: assert property (@(posedge clk) disable iff (clr)
    (hit && seen == 3'd4) |-> $past(din));

  // R8: only legal codes
  p_legal_state_r8: assert property (@(posedge clk) disable iff (clr)
    st_q < ST_W'(N_LEGAL));
endmodule

bind pat1101_moore pat1101_chk u_chk (
  .clk  (clk),
  .clr  (clr),
  .din  (din),
  .hit  (hit),
  .st_q (st_q)
);

// File: tb/sim_pat1101_moore.sv
`timescale 1ns/1ps
module sim_pat1101_moore;
  logic clk = 1'b0;
  logic clr = 1'b1;
  logic din = 1'b0;
  logic hit;

  int n_chk = 0;
  int n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  logic [3:0] m_hist = '0;
  int m_seen = 0;

  always #2 clk = ~clk;

  pat1101_moore u0 (.clk(clk), .clr(clr), .din(din), .hit(hit));

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: hit=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(input logic b, input string tag);
    logic e;
    @(negedge clk);
    din = b;
    m_hist = {m_hist[2:0], b};
    if (m_seen < 4) m_seen++;
    e = (m_seen == 4) && (m_hist == 4'b1101);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic send_seq(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) send(bits[i], tag);
  endtask

  task automatic do_clear(input string tag);
    @(negedge clk);
    clr = 1'b1;
    #1;
    check(hit, 1'b0, tag);
    m_hist = '0;
    m_seen = 0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: compare one queued result per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(hit, e, t);
      end
    end
  end

  initial begin
    #80000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: hit=%b expected run end", hit);
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check(hit, 1'b0, "R1 reset");
    @(negedge clk);
    clr = 1'b0;
    // R1: first three bits after reset never hit
    send_seq(16'b110, 3, "R1");
    do_clear("R1 clear");
    // R3 R5 R2: overlapping stream 1101101001101
    send_seq(16'b1101101001101, 13, "R3 R5");
    // R4: clear while hit is high drops it mid-cycle
    do_clear("R4 async");
    // R4: partial 110 then clear, then a lone 1 must not hit
    send_seq(16'b110, 3, "R4 partial");
    do_clear("R4 mid");
    send(1'b1, "R4 no carry");
    send_seq(16'b1101, 4, "R4 full");
    do_clear("R4");
    // R7: run of ones
    send_seq(16'b111101, 6, "R7");
    // R9: zero after 110
    send_seq(16'b11001101, 8, "R9");
    // R6 R8: back-to-back overlap, plus zeros
    send_seq(16'b1101101101, 10, "R6 R8");
    send_seq(16'b0000, 4, "R2 R8");
    @(posedge clk);
    #2;
    finish_run();
  end
endmodule